// File: doc/BRIEF.md
# Two-Level Mixed-Page-Size Address Translation Cache

This block caches virtual-to-physical page translations in two levels. The first level is fully associative and is searched in full on every lookup. It has two fixed partitions: 24 entries hold 4 KB pages, and 8 entries hold 2 MB or 4 MB pages, with a size bit per entry. The second level is a 4-way set-associative store of 256 entries that keeps 4 KB translations only. A first-level hit answers one cycle after the lookup is accepted. A first-level miss costs one extra probe cycle in the second level. On a second-level hit, the translation is copied into the small-page partition of the first level. A miss in both levels produces a fill request.

Page-table walking is not part of the block. An external agent watches the fill request and then writes the translation through the fill port, giving the page size. A 4 KB fill is written to both levels. A large-page fill is written to the large partition only. A single invalidate input clears every entry of both levels in one cycle.

Control is a two-state machine:
- `ST_IDLE` accepts lookups.
- `ST_L2_PROBE` searches the second level for the held address.

Transitions:
- `ST_IDLE` moves to `ST_L2_PROBE` when an accepted lookup misses the first level. Otherwise it stays in `ST_IDLE`.
- `ST_L2_PROBE` always returns to `ST_IDLE` after one cycle.

Top module: `xlat_tlb2`

## Requirements
- R1: After reset, `lk_ready` is 1, `rsp_valid` and `fill_req` are 0, and every entry of both levels is invalid, so the first lookup misses.
- R2: A lookup that matches a valid small first-level entry on address bits [31:12] returns `rsp_valid`=1, `rsp_hit`=1 and `rsp_paddr`={frame, va[11:0]} in the cycle after acceptance.
- R3: Fill size code 2'b01 means 2 MB: the entry matches on va[31:21] and returns {ppn[19:9], va[20:0]}. Code 2'b10 means 4 MB: the entry matches on va[31:22] and returns {ppn[19:10], va[21:0]}. Both answer one cycle after acceptance.
- R4: A first-level miss that hits the second level holds `lk_ready` low for one probe cycle. It answers with a hit two cycles after acceptance and copies the translation into the small partition, so the next lookup of that page answers in one cycle.
- R5: A miss in both levels answers two cycles after acceptance with `rsp_hit`=0 and a one-cycle `fill_req`, and `miss_vaddr` equals the looked-up address.
- R6: Fill size code 2'b00 (4 KB) writes both levels. A large-page fill writes only the large partition, so once that entry has been replaced the page misses in both levels.
- R7: Each first-level partition replaces its entries round-robin. The pointer advances on every write to that partition, including copies from the second level.
- R8: The second-level set is va[17:12]. A fill takes the lowest-numbered invalid way, or else the tree pseudo-LRU victim. Both hits and fills update the tree.
- R9: `inv_all` invalidates every entry in both levels in one cycle and returns the round-robin pointers and the pseudo-LRU trees to zero.
- R10: A fill with size code 2'b11 writes nothing.
- R11: Only one lookup is in flight. `lk_valid` is ignored while `lk_ready` is low and produces no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_ready | output | 1 | High when a lookup can be accepted |
| rsp_valid | output | 1 | Lookup result is valid |
| rsp_hit | output | 1 | Translation found |
| rsp_paddr | output | 32 | Translated physical address |
| fill_req | output | 1 | Both levels missed; a fill is wanted |
| miss_vaddr | output | 32 | Address that missed |
| fill_valid | input | 1 | Fill write strobe |
| fill_size | input | 2 | 00 = 4 KB, 01 = 2 MB, 10 = 4 MB, 11 = no write |
| fill_vpn | input | 20 | Virtual address bits [31:12] of the page |
| fill_ppn | input | 20 | Physical address bits [31:12] of the frame |
| inv_all | input | 1 | Invalidate every entry |

## Verification
The hardest case to reach from the ports is pseudo-LRU replacement inside one second-level set. It only shows up when a first-level miss reaches a set whose four ways are full. The first level also has to have forgotten the page, which takes 24 newer small-page writes. The directed phase fills five pages into one set, floods the small partition with pages that map to other sets, and then shows that the tree victim misses while its neighbours still hit at two-cycle latency. The random phase draws small pages from 32 addresses packed into four sets, so first-level eviction and second-level eviction overlap constantly. A bench model tracks both partitions, the pointers and the trees.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int VA_W     = 32;
    localparam int PAGE_SH  = 12;
    localparam int VPN_W    = VA_W - PAGE_SH;
    localparam int PPN_W    = 20;
    localparam int L2_WAYS  = 4;
    localparam int WAY_W    = 2;
    localparam int BIG_W    = VA_W - 21;   // tag/frame width for 2 MB granularity

    typedef enum logic [1:0] {
        PG_4K  = 2'b00,
        PG_2M  = 2'b01,
        PG_4M  = 2'b10,
        PG_BAD = 2'b11
    } pg_size_e;

    typedef enum logic {
        ST_IDLE,
        ST_L2_PROBE
    } walk_st_e;

    function automatic logic [WAY_W-1:0] plru_victim(input logic [2:0] t);
        if (!t[0]) plru_victim = t[1] ? 2'd1 : 2'd0;
        else       plru_victim = t[2] ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
        if (w < 2) plru_touch = {t[2], (w == 2'd0), 1'b1};
        else       plru_touch = {(w == 2'd2), t[1], 1'b0};
    endfunction
endpackage

// File: rtl/xlat_l1_small.sv
module xlat_l1_small
    import xlat_pkg::*;
#(
    parameter int N = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_va,
    output logic              hit,
    output logic [VA_W-1:0]   pa,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]  wr_ppn
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic             ent_v   [N];
    logic [VPN_W-1:0] ent_vpn [N];
    logic [PPN_W-1:0] ent_ppn [N];
    logic [PTR_W-1:0] ptr;
    logic [N-1:0]     match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent_v[i] && (ent_vpn[i] == lk_va[VA_W-1:PAGE_SH]);
    end

    // lowest index wins
    always_comb begin
        hit = 1'b0;
        pa  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                pa  = {ent_ppn[i], lk_va[PAGE_SH-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int i = 0; i < N; i++) ent_v[i] <= 1'b0;
            ptr <= '0;
        end else if (wr_en) begin
            ent_v[ptr]   <= 1'b1;
            ent_vpn[ptr] <= wr_vpn;
            ent_ppn[ptr] <= wr_ppn;
            ptr <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_l1_large.sv
module xlat_l1_large
    import xlat_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_va,
    output logic              hit,
    output logic [VA_W-1:0]   pa,
    input  logic              wr_en,
    input  logic              wr_is4m,
    input  logic [BIG_W-1:0]  wr_tag,
    input  logic [BIG_W-1:0]  wr_ppn
);
    localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

    logic             ent_v   [N];
    logic             ent_4m  [N];
    logic [BIG_W-1:0] ent_tag [N];
    logic [BIG_W-1:0] ent_ppn [N];
    logic [PTR_W-1:0] ptr;
    logic [N-1:0]     match;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign match[i] = ent_v[i] && (ent_4m[i]
                        ? (ent_tag[i][BIG_W-1:1] == lk_va[VA_W-1:22])
                        : (ent_tag[i] == lk_va[VA_W-1:21]));
    end

    always_comb begin
        hit = 1'b0;
        pa  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                pa  = ent_4m[i] ? {ent_ppn[i][BIG_W-1:1], lk_va[21:0]}
                                : {ent_ppn[i], lk_va[20:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int i = 0; i < N; i++) ent_v[i] <= 1'b0;
            ptr <= '0;
        end else if (wr_en) begin
            ent_v[ptr]   <= 1'b1;
            ent_4m[ptr]  <= wr_is4m;
            ent_tag[ptr] <= wr_tag;
            ent_ppn[ptr] <= wr_ppn;
            ptr <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/xlat_l2_set4.sv
module xlat_l2_set4
    import xlat_pkg::*;
#(
    parameter int SETS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv_all,
    input  logic [VA_W-1:0]   lk_va,
    output logic              hit,
    output logic [VA_W-1:0]   pa,
    output logic [WAY_W-1:0]  hit_way,
    input  logic              touch_en,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;

    logic             way_v   [SETS][L2_WAYS];
    logic [TAG_W-1:0] way_tag [SETS][L2_WAYS];
    logic [PPN_W-1:0] way_ppn [SETS][L2_WAYS];
    logic [2:0]       tree    [SETS];

    logic [IDX_W-1:0] l_set, f_set;
    logic [TAG_W-1:0] l_tag, f_tag;
    logic [L2_WAYS-1:0] l_match;
    logic [WAY_W-1:0] f_way;
    logic [2:0]       l_tree_nx, f_tree_base;

    assign l_set = lk_va[PAGE_SH +: IDX_W];
    assign l_tag = lk_va[VA_W-1 -: TAG_W];
    assign f_set = fill_vpn[IDX_W-1:0];
    assign f_tag = fill_vpn[VPN_W-1 -: TAG_W];

    for (genvar w = 0; w < L2_WAYS; w++) begin : g_way
        assign l_match[w] = way_v[l_set][w] && (way_tag[l_set][w] == l_tag);
    end

    always_comb begin
        hit     = 1'b0;
        hit_way = '0;
        pa      = '0;
        for (int w = L2_WAYS - 1; w >= 0; w--) begin
            if (l_match[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
                pa      = {way_ppn[l_set][w], lk_va[PAGE_SH-1:0]};
            end
        end
    end

    // victim: lowest invalid way, else tree choice
    always_comb begin
        f_way = plru_victim(tree[f_set]);
        for (int w = L2_WAYS - 1; w >= 0; w--) begin
            if (!way_v[f_set][w]) f_way = WAY_W'(w);
        end
    end

    assign l_tree_nx   = plru_touch(tree[l_set], hit_way);
    assign f_tree_base = (touch_en && hit && (f_set == l_set)) ? l_tree_nx : tree[f_set];

    always_ff @(posedge clk) begin
        if (!rst_n || inv_all) begin
            for (int s = 0; s < SETS; s++) begin
                tree[s] <= '0;
                for (int w = 0; w < L2_WAYS; w++) way_v[s][w] <= 1'b0;
            end
        end else begin
            if (touch_en && hit) tree[l_set] <= l_tree_nx;
            if (fill_en) begin
                way_v[f_set][f_way]   <= 1'b1;
                way_tag[f_set][f_way] <= f_tag;
                way_ppn[f_set][f_way] <= fill_ppn;
                tree[f_set]           <= plru_touch(f_tree_base, f_way);
            end
        end
    end
endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2
    import xlat_pkg::*;
#(
    parameter int L1_SMALL = 24,
    parameter int L1_LARGE = 8,
    parameter int L2_SETS  = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [31:0] lk_vaddr,
    output logic        lk_ready,
    output logic        rsp_valid,
    output logic        rsp_hit,
    output logic [31:0] rsp_paddr,
    output logic        fill_req,
    output logic [31:0] miss_vaddr,
    input  logic        fill_valid,
    input  logic [1:0]  fill_size,
    input  logic [19:0] fill_vpn,
    input  logic [19:0] fill_ppn,
    input  logic        inv_all
);
    walk_st_e state, state_nx;
    pg_size_e fsz;

    logic [VA_W-1:0] hold_va;
    logic accept;
    logic fill_small, fill_large;
    logic s_hit, l_hit, l1_hit, l2_hit;
    logic [VA_W-1:0] s_pa, l_pa, l1_pa, l2_pa;
    logic [WAY_W-1:0] l2_way;
    logic refill, s_wr_en, probing;
    logic [VPN_W-1:0] s_wr_vpn;
    logic [PPN_W-1:0] s_wr_ppn;

    assign fsz        = pg_size_e'(fill_size);
    assign fill_small = fill_valid && (fsz == PG_4K);
    assign fill_large = fill_valid && ((fsz == PG_2M) || (fsz == PG_4M));
    assign lk_ready   = (state == ST_IDLE);
    assign accept     = lk_valid && lk_ready;
    assign probing    = (state == ST_L2_PROBE);

    assign l1_hit = s_hit || l_hit;
    assign l1_pa  = s_hit ? s_pa : l_pa;

    // copy from second level; a same-cycle 4 KB fill takes the write port
    assign refill   = probing && l2_hit && !fill_small;
    assign s_wr_en  = fill_small || refill;
    assign s_wr_vpn = fill_small ? fill_vpn : hold_va[VA_W-1:PAGE_SH];
    assign s_wr_ppn = fill_small ? fill_ppn : l2_pa[VA_W-1:PAGE_SH];

    xlat_l1_small #(.N(L1_SMALL)) small_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_va(lk_vaddr), .hit(s_hit), .pa(s_pa),
        .wr_en(s_wr_en), .wr_vpn(s_wr_vpn), .wr_ppn(s_wr_ppn)
    );

    xlat_l1_large #(.N(L1_LARGE)) large_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_va(lk_vaddr), .hit(l_hit), .pa(l_pa),
        .wr_en(fill_large), .wr_is4m(fsz == PG_4M),
        .wr_tag(fill_vpn[VPN_W-1:9]), .wr_ppn(fill_ppn[PPN_W-1:9])
    );

    xlat_l2_set4 #(.SETS(L2_SETS)) l2_i (
        .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
        .lk_va(hold_va), .hit(l2_hit), .pa(l2_pa), .hit_way(l2_way),
        .touch_en(probing), .fill_en(fill_small),
        .fill_vpn(fill_vpn), .fill_ppn(fill_ppn)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept && !l1_hit) state_nx = ST_L2_PROBE;
            ST_L2_PROBE: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_hit    <= 1'b0;
            rsp_paddr  <= '0;
            fill_req   <= 1'b0;
            miss_vaddr <= '0;
            hold_va    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            fill_req  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        hold_va <= lk_vaddr;
                        if (l1_hit) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b1;
                            rsp_paddr <= l1_pa;
                        end
                    end
                end
                ST_L2_PROBE: begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= l2_hit;
                    rsp_paddr <= l2_hit ? l2_pa : '0;
                    if (!l2_hit) begin
                        fill_req   <= 1'b1;
                        miss_vaddr <= hold_va;
                    end
                end
            endcase
        end
    end

    logic unused_way;
    assign unused_way = ^l2_way;
endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk (
    input logic clk,
    input logic rst_n,
    input logic lk_valid,
    input logic lk_ready,
    input logic rsp_valid,
    input logic rsp_hit,
    input logic fill_req,
    input logic fill_valid,
    input logic inv_all
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !fill_req && lk_ready));

    p_accept_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> (rsp_valid || !lk_ready));

    p_probe_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |=> rsp_valid);

    p_fill_req_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req |-> (rsp_valid && !rsp_hit));

    p_inv_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(inv_all) && lk_valid && lk_ready && !fill_valid)
        |=> (!rsp_valid ##1 (rsp_valid && !rsp_hit)));

    p_probe_one_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_ready |=> lk_ready);

    p_no_spurious_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_ready && !lk_valid) |=> !rsp_valid);
endmodule

bind xlat_tlb2 xlat_tlb2_chk chk_i (.*);

// File: tb/xlat_tlb2_tb.sv
module xlat_tlb2_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 24, NL = 8, NSET = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_ready, rsp_valid, rsp_hit, fill_req;
    logic [31:0] rsp_paddr, miss_vaddr;
    logic        fill_valid = 1'b0;
    logic [1:0]  fill_size = '0;
    logic [19:0] fill_vpn = '0, fill_ppn = '0;
    logic        inv_all = 1'b0;

    int checks = 0, errors = 0;

    xlat_tlb2 dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference state
    logic        m_sv [NS];  logic [19:0] m_svpn [NS]; logic [19:0] m_sppn [NS]; int m_sptr;
    logic        m_lv [NL];  logic m_l4m [NL]; logic [10:0] m_ltag [NL]; logic [10:0] m_lppn [NL]; int m_lptr;
    logic        m_v2 [NSET][4]; logic [13:0] m_t2 [NSET][4]; logic [19:0] m_p2 [NSET][4]; logic [2:0] m_tr [NSET];

    function automatic logic [1:0] b_victim(logic [2:0] t);
        return !t[0] ? (t[1] ? 2'd1 : 2'd0) : (t[2] ? 2'd3 : 2'd2);
    endfunction
    function automatic logic [2:0] b_touch(logic [2:0] t, logic [1:0] w);
        return (w < 2) ? {t[2], (w == 2'd0), 1'b1} : {(w == 2'd2), t[1], 1'b0};
    endfunction

    task automatic m_inv();
        for (int i = 0; i < NS; i++) m_sv[i] = 1'b0;
        for (int i = 0; i < NL; i++) m_lv[i] = 1'b0;
        for (int s = 0; s < NSET; s++) begin
            m_tr[s] = '0;
            for (int w = 0; w < 4; w++) m_v2[s][w] = 1'b0;
        end
        m_sptr = 0; m_lptr = 0;
    endtask

    task automatic m_small_wr(logic [19:0] vpn, logic [19:0] ppn);
        m_sv[m_sptr] = 1'b1; m_svpn[m_sptr] = vpn; m_sppn[m_sptr] = ppn;
        m_sptr = (m_sptr + 1) % NS;
    endtask

    task automatic m_l2_wr(logic [19:0] vpn, logic [19:0] ppn);
        int s; logic [1:0] w; bit found;
        s = int'(vpn[5:0]); found = 0; w = b_victim(m_tr[s]);
        for (int k = 0; k < 4; k++) if (!found && !m_v2[s][k]) begin w = 2'(k); found = 1; end
        m_v2[s][w] = 1'b1; m_t2[s][w] = vpn[19:6]; m_p2[s][w] = ppn;
        m_tr[s] = b_touch(m_tr[s], w);
    endtask

    // kind: 0 first level, 1 second level, 2 miss
    task automatic m_lookup(logic [31:0] va, output int kind, output logic [31:0] pa, output logic [1:0] way);
        kind = 2; pa = '0; way = '0;
        for (int i = NS - 1; i >= 0; i--)
            if (m_sv[i] && m_svpn[i] == va[31:12]) begin kind = 0; pa = {m_sppn[i], va[11:0]}; end
        if (kind == 2)
            for (int i = NL - 1; i >= 0; i--)
                if (m_lv[i] && (m_l4m[i] ? (m_ltag[i][10:1] == va[31:22]) : (m_ltag[i] == va[31:21]))) begin
                    kind = 0;
                    pa = m_l4m[i] ? {m_lppn[i][10:1], va[21:0]} : {m_lppn[i], va[20:0]};
                end
        if (kind == 2)
            for (int w = 3; w >= 0; w--)
                if (m_v2[va[17:12]][w] && m_t2[va[17:12]][w] == va[31:18]) begin
                    kind = 1; way = 2'(w); pa = {m_p2[va[17:12]][w], va[11:0]};
                end
    endtask

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic do_lookup(logic [31:0] va, string req, output int kind);
        logic [31:0] epa; logic [1:0] ew; int lat; bit ok;
        m_lookup(va, kind, epa, ew);
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = va;
        @(negedge clk); lk_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 4) begin @(negedge clk); lat++; end
        if (kind == 0)      ok = (lat == 1) && rsp_hit && (rsp_paddr == epa) && !fill_req;
        else if (kind == 1) ok = (lat == 2) && rsp_hit && (rsp_paddr == epa) && !fill_req;
        else                ok = (lat == 2) && !rsp_hit && fill_req && (miss_vaddr == va);
        chk(ok, req, $sformatf("lookup va=%h kind=%0d lat=%0d hit=%b freq=%b", va, kind, lat, rsp_hit, fill_req),
            rsp_paddr, epa);
        if (kind == 1) begin
            m_tr[va[17:12]] = b_touch(m_tr[va[17:12]], ew);
            m_small_wr(va[31:12], epa[31:12]);
        end
    endtask

    task automatic do_fill(logic [19:0] vpn, logic [1:0] sz, logic [19:0] ppn);
        @(negedge clk); fill_valid = 1'b1; fill_size = sz; fill_vpn = vpn; fill_ppn = ppn;
        @(negedge clk); fill_valid = 1'b0;
        if (sz == 2'b00) begin m_small_wr(vpn, ppn); m_l2_wr(vpn, ppn); end
        else if (sz != 2'b11) begin
            m_lv[m_lptr] = 1'b1; m_l4m[m_lptr] = (sz == 2'b10);
            m_ltag[m_lptr] = vpn[19:9]; m_lppn[m_lptr] = ppn[19:9];
            m_lptr = (m_lptr + 1) % NL;
        end
    endtask

    task automatic do_inv();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        m_inv();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R11 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int k;
        logic [31:0] va;
        void'($urandom(32'd20241));
        m_inv();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lk_ready && !rsp_valid && !fill_req, "R1", "reset outputs", {29'd0, lk_ready, rsp_valid, fill_req}, 32'd4);
        do_lookup(32'h0000_5123, "R1", k);
        chk(k == 2, "R5", "empty miss kind", k, 2);

        do_fill(20'h00005, 2'b00, 20'h12345);
        do_lookup(32'h0000_5ABC, "R2", k);
        chk(rsp_paddr == 32'h1234_5ABC, "R2", "small paddr", rsp_paddr, 32'h1234_5ABC);

        do_fill(20'hB0201, 2'b01, 20'hABC00);
        do_lookup(32'hB03F_F00F, "R3", k);
        chk(rsp_paddr == {11'h55E, 21'h1F_F00F}, "R3", "2MB paddr", rsp_paddr, {11'h55E, 21'h1F_F00F});
        do_fill(20'hC0400, 2'b10, 20'h77700);
        do_lookup(32'hC07A_BCDE, "R3", k);
        chk(rsp_paddr == {10'h1DD, 22'h3A_BCDE}, "R3", "4MB paddr", rsp_paddr, {10'h1DD, 22'h3A_BCDE});

        for (int i = 0; i < 24; i++) do_fill(20'(100 + i), 2'b00, 20'(32'h40000 + i));
        do_lookup(32'h0000_5004, "R7", k);
        chk(k == 1, "R4", "evicted page from second level", k, 1);
        do_lookup(32'h0000_5008, "R4", k);
        chk(k == 0, "R4", "refilled page one cycle", k, 0);
        do_lookup(32'h0006_4000, "R7", k);

        for (int t = 1; t <= 5; t++) do_fill(20'((t << 6) | 7), 2'b00, 20'(32'h50000 + t));
        for (int i = 0; i < 24; i++) do_fill(20'(200 + i), 2'b00, 20'(32'h60000 + i));
        do_lookup({20'((1 << 6) | 7), 12'h010}, "R8", k);
        chk(k == 2, "R8", "pseudo-LRU victim gone", k, 2);
        do_lookup({20'((2 << 6) | 7), 12'h010}, "R8", k);
        chk(k == 1, "R8", "neighbour kept", k, 1);

        do_fill(20'h00300, 2'b11, 20'h11111);
        do_lookup(32'h0030_0000, "R10", k);
        chk(k == 2, "R10", "bad size wrote", k, 2);

        do_fill(20'hD0000, 2'b01, 20'h22200);
        for (int i = 1; i <= 8; i++) do_fill(20'(32'hD0000 + (i << 9)), 2'b01, 20'h33300);
        do_lookup(32'hD000_0100, "R6", k);
        chk(k == 2, "R6", "large page not in second level", k, 2);

        do_inv();
        do_lookup(32'h0000_5000, "R9", k);
        chk(k == 2, "R9", "after invalidate small", k, 2);
        do_lookup(32'hC040_0000, "R9", k);
        chk(k == 2, "R9", "after invalidate large", k, 2);

        // second request during probe cycle must be dropped
        @(negedge clk); lk_valid = 1'b1; lk_vaddr = 32'h0000_9000;
        @(negedge clk); lk_vaddr = 32'h0000_A000;
        chk(!lk_ready, "R11", "ready low in probe", {31'd0, lk_ready}, 32'd0);
        @(negedge clk); lk_valid = 1'b0;
        chk(rsp_valid && !rsp_hit && miss_vaddr == 32'h0000_9000, "R11", "first answered", miss_vaddr, 32'h0000_9000);
        @(negedge clk);
        chk(!rsp_valid, "R11", "no second response", {31'd0, rsp_valid}, 32'd0);

        for (int n = 0; n < 500; n++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2) do_inv();
            else if (r < 4) do_fill(20'($urandom % 512), 2'b11, 20'($urandom));
            else if (r < 72) begin
                va = {12'd0, 3'($urandom % 8), 4'd0, 1'b0, 2'($urandom % 4), 12'($urandom)};
                do_lookup(va, "R8", k);
                if (k == 2) do_fill(va[31:12], 2'b00, 20'($urandom));
            end else begin
                int la;
                la = int'($urandom % 12);
                va = 32'hA000_0000 | (32'(la) << 22) | ($urandom & 32'h003F_FFFF);
                do_lookup(va, "R3", k);
                if (k == 2) do_fill(va[31:12], (la % 2 == 0) ? 2'b10 : 2'b01, 20'($urandom));
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule